// File: doc/BRIEF.md
# Pixel Readout Frame Builder

This block turns a stream of pixel hit records into framed 40-bit output words for a triggerless pixel readout chip. A frame opens with a header word carrying the chip's identity and a running frame number. One event word follows for every hit accepted while the frame is open, and a trailer word closes the frame. The trailer reports how many events the frame held and a CRC over every word that came before it. Each 40-bit word becomes 50 line bits after 8b/10b encoding, which happens downstream together with serialization.

Hits arrive on a valid/ready interface. The frame edges are marked by two single-cycle controls, `frame_start` and `frame_end`. Output words leave on a valid/ready stream through a single output register. A controller with five states sequences the frame. `IDLE` waits for `frame_start` and loads the header (IDLE→HEAD). `HEAD` holds the header until the sink takes it (HEAD→BODY). `BODY` accepts hits and turns each into an event word; `frame_end` moves it on (BODY→FLUSH). `FLUSH` waits until any last event word has been taken, then loads the trailer (FLUSH→TRAIL). `TRAIL` holds the trailer until it is taken (TRAIL→IDLE). `frame_end` has no effect outside `BODY`, and `frame_start` has no effect outside `IDLE`.

Top module: `pfb_builder`

## Requirements
- R1: During and after reset `out_valid` and `hit_ready` are 0. The first frame after reset carries frame number 0.
- R2: A frame is exactly one header word, then one event word per accepted hit in acceptance order, then one trailer word. Bits [39:38] hold the word type: 2'b01 for a header, 2'b10 for an event and 2'b11 for a trailer.
- R3: A header word carries `chip_id` in bits [37:26], the frame number in bits [25:18], and zeros in bits [17:6].
- R4: An event word carries the hit's pixel address in bits [37:24], its leading time in bits [23:12] and its trailing time in bits [11:0].
- R5: Header and trailer words carry a Hamming check in bits [5:0], computed over payload bits [39:6]. Payload bit j (word bit j+6) takes the j-th integer, counting from 3 upward, that is not a power of two. Check bit k is the XOR of every payload bit whose integer has bit k set.
- R6: A trailer word carries the frame's event count in bits [37:22] and the frame CRC in bits [21:6].
- R7: The CRC uses polynomial 0x1021 and starts from 0xFFFF. It is fed the 40 bits of the header and of each event word, most significant bit first. The trailer itself is not included.
- R8: The frame number rises by one each time a trailer is taken and wraps from 255 to 0.
- R9: The trailer event count saturates at 0xFFFF.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_word` hold their values into the next cycle.
- R11: A `frame_end` pulse while no frame is open produces no output. A `frame_start` pulse while a frame is open neither disturbs that frame nor adds a frame number.
- R12: `hit_ready` is 1 only in BODY, and never in a cycle in which `frame_end` is 1. A hit is therefore never accepted in the cycle that closes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 12 | Chip address placed in each header |
| frame_start | input | 1 | Opens a frame when the block is idle |
| frame_end | input | 1 | Closes the open frame when the block is in BODY |
| hit_valid | input | 1 | A hit record is offered |
| hit_ready | output | 1 | The offered hit is taken at this edge |
| hit_pixel | input | 14 | Pixel address of the hit |
| hit_lead | input | 12 | Leading-edge time of the hit |
| hit_trail | input | 12 | Trailing-edge time of the hit |
| out_valid | output | 1 | `out_word` holds a word |
| out_ready | input | 1 | The sink takes `out_word` at this edge |
| out_word | output | 40 | Frame word |

## Verification
The assertions assume the following about the inputs:
- The sink obeys the stream handshake.
- `frame_end` comes as a short pulse.
- `chip_id` only matters when a header is loaded.

The stimulus raises `frame_end` only after the header has been taken, and drops each hit once it has been accepted. It changes `out_ready` in several fixed patterns: always ready, ready two cycles out of three, ready two cycles out of five, and held low. Under all of these patterns the stalls land on header, event and trailer words. Out-of-place controls are applied on purpose to show that they are ignored: `frame_end` while idle, and `frame_start` while a frame is open.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int WORD_W    = 40;
    localparam int TYPE_W    = 2;
    localparam int ECC_W     = 6;
    localparam int CHIP_W    = 12;
    localparam int FNUM_W    = 8;
    localparam int PIX_W     = 14;
    localparam int TIME_W    = 12;
    localparam int CNT_W     = 16;
    localparam int CRC_W     = 16;
    localparam int PAYLOAD_W = WORD_W - ECC_W;
    localparam int HPAD_W    = PAYLOAD_W - TYPE_W - CHIP_W - FNUM_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [TYPE_W-1:0] {
        WT_HDR = 2'b01,
        WT_EVT = 2'b10,
        WT_TRL = 2'b11
    } pfb_wtype_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_FLUSH,
        S_TRAIL
    } pfb_state_e;

    // Mask of payload bits covered by check bit k: payload bit j sits at
    // the j-th non-power-of-two position counted from 3.
    function automatic logic [63:0] pfb_hmask(int k, int dw);
        logic [63:0] m;
        int seen;
        m = '0;
        seen = 0;
        for (int p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen < dw && ((p >> k) & 1) == 1) m[seen] = 1'b1;
                seen++;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/pfb_ecc.sv
module pfb_ecc #(
    parameter int DATA_W = 34,
    parameter int CHK_W  = 6
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [63:0]       MFULL = pfb_pkg::pfb_hmask(k, DATA_W);
        localparam logic [DATA_W-1:0] MASK  = MFULL[DATA_W-1:0];
        assign chk[k] = ^(data & MASK);
    end
endmodule

// File: rtl/pfb_crc.sv
module pfb_crc #(
    parameter int              DATA_W = 40,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/pfb_builder.sv
module pfb_builder
    import pfb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHIP_W-1:0]     chip_id,
    input  logic                  frame_start,
    input  logic                  frame_end,
    input  logic                  hit_valid,
    output logic                  hit_ready,
    input  logic [PIX_W-1:0]      hit_pixel,
    input  logic [TIME_W-1:0]     hit_lead,
    input  logic [TIME_W-1:0]     hit_trail,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [WORD_W-1:0]     out_word
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE = 1;
    localparam logic [FNUM_W-1:0] FNUM_ONE = 1;

    pfb_state_e           state_q, state_d;
    logic [WORD_W-1:0]    word_q;
    logic                 wvld_q;
    logic [CRC_W-1:0]     crc_q;
    logic [CRC_W-1:0]     crc_step;
    logic [CRC_W-1:0]     crc_final;
    logic [CNT_W-1:0]     cnt_q;
    logic [FNUM_W-1:0]    fnum_q;
    logic [PAYLOAD_W-1:0] hdr_pl;
    logic [PAYLOAD_W-1:0] trl_pl;
    logic [PAYLOAD_W-1:0] chk_src;
    logic [ECC_W-1:0]     chk;
    logic                 out_take;
    logic                 hit_take;
    logic                 flush_go;

    assign out_valid = wvld_q;
    assign out_word  = word_q;
    assign out_take  = wvld_q && out_ready;
    assign hit_ready = (state_q == S_BODY) && !frame_end && (!wvld_q || out_ready);
    assign hit_take  = hit_valid && hit_ready;
    assign flush_go  = !wvld_q || out_ready;

    // CRC advance over the word currently held in the output register
    pfb_crc #(
        .DATA_W (WORD_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_q),
        .data    (word_q),
        .crc_out (crc_step)
    );

    assign crc_final = wvld_q ? crc_step : crc_q;
    assign hdr_pl    = {WT_HDR, chip_id, fnum_q, {HPAD_W{1'b0}}};
    assign trl_pl    = {WT_TRL, cnt_q, crc_final};
    assign chk_src   = (state_q == S_IDLE) ? hdr_pl : trl_pl;

    // One encoder shared by header (loaded in IDLE) and trailer (in FLUSH)
    pfb_ecc #(
        .DATA_W (PAYLOAD_W),
        .CHK_W  (ECC_W)
    ) u_ecc (
        .data (chk_src),
        .chk  (chk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frame_start) state_d = S_HEAD;
            S_HEAD:  if (out_take)    state_d = S_BODY;
            S_BODY:  if (frame_end)   state_d = S_FLUSH;
            S_FLUSH: if (flush_go)    state_d = S_TRAIL;
            S_TRAIL: if (out_take)    state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            wvld_q <= 1'b0;
            crc_q  <= CRC_SEED;
            cnt_q  <= '0;
            fnum_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (frame_start) begin
                        word_q <= {hdr_pl, chk};
                        wvld_q <= 1'b1;
                        crc_q  <= CRC_SEED;
                        cnt_q  <= '0;
                    end
                end
                S_HEAD: begin
                    if (out_take) begin
                        wvld_q <= 1'b0;
                        crc_q  <= crc_step;
                    end
                end
                S_BODY: begin
                    if (out_take) begin
                        wvld_q <= 1'b0;
                        crc_q  <= crc_step;
                    end
                    if (hit_take) begin
                        word_q <= {WT_EVT, hit_pixel, hit_lead, hit_trail};
                        wvld_q <= 1'b1;
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                S_FLUSH: begin
                    if (flush_go) begin
                        word_q <= {trl_pl, chk};
                        wvld_q <= 1'b1;
                        crc_q  <= crc_final;
                    end
                end
                S_TRAIL: begin
                    if (out_take) begin
                        wvld_q <= 1'b0;
                        fnum_q <= fnum_q + FNUM_ONE;
                    end
                end
                default: wvld_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pfb_builder_chk.sv
module pfb_builder_chk
    import pfb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic              hit_valid,
    input logic              hit_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [FNUM_W-1:0] fnum_q,
    input pfb_state_e        state_q
);
    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1 -: TYPE_W] != 2'b00); // R2

    AST_EVENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_ready) |=> (out_valid && out_word[WORD_W-1 -: TYPE_W] == WT_EVT)); // R4

    AST_FNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_word[WORD_W-1 -: TYPE_W] == WT_TRL)
        |=> (fnum_q == FNUM_W'($past(fnum_q) + 1'b1))); // R8

    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && cnt_q == '1) |=> (cnt_q == '1)); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R10

    AST_END_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !hit_ready); // R12
endmodule

bind pfb_builder pfb_builder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .hit_valid (hit_valid),
    .hit_ready (hit_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .cnt_q     (cnt_q),
    .fnum_q    (fnum_q),
    .state_q   (state_q)
);

// File: tb/test_pfb_builder.sv
module test_pfb_builder;
    localparam logic [11:0] CHIP = 12'hA5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] chip_id = CHIP;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [13:0] hit_pixel = '0;
    logic [11:0] hit_lead = '0;
    logic [11:0] hit_trail = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [39:0] out_word;

    int nchk = 0;
    int nfail = 0;
    int nwords = 0;
    int stall_mode = 0;
    int cyc = 0;
    int stab_err = 0;
    logic [39:0] cap [64];
    logic [39:0] last_w;
    logic [7:0]  exp_fc = 8'd0;
    logic        prev_v = 1'b0;
    logic        prev_r = 1'b1;
    logic [39:0] prev_w = '0;

    pfb_builder i_pfb_builder (
        .clk, .rst_n, .chip_id, .frame_start, .frame_end,
        .hit_valid, .hit_ready, .hit_pixel, .hit_lead, .hit_trail,
        .out_valid, .out_ready, .out_word
    );

    always #2 clk = ~clk;

    // Sink readiness pattern, changed just after each rising edge
    always @(posedge clk) begin
        cyc++;
        #1;
        case (stall_mode)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = (cyc % 5) < 2;
            3:       out_ready = 1'b0;
            default: out_ready = 1'b1;
        endcase
    end

    // Word capture and hold check, sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && !prev_r && !(out_valid && out_word == prev_w)) stab_err++;
            if (out_valid && out_ready) begin
                if (nwords < 64) cap[nwords] = out_word;
                last_w = out_word;
                nwords++;
            end
            prev_v = out_valid;
            prev_r = out_ready;
            prev_w = out_word;
        end
    end

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ecc_ref(input logic [33:0] d);
        logic [5:0] e = '0;
        int di = 0;
        for (int pos = 1; pos <= 40; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                for (int k = 0; k < 6; k++) if (pos[k]) e[k] = e[k] ^ d[di];
                di++;
            end
        end
        return e;
    endfunction

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [39:0] w);
        logic [15:0] r = c;
        for (int b = 39; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [39:0] hdr_ref(input logic [7:0] fc);
        logic [33:0] p = {2'b01, CHIP, fc, 12'h000};
        return {p, ecc_ref(p)};
    endfunction

    function automatic logic [39:0] ev_ref(input int seed, input int i);
        logic [13:0] p = 14'(seed * 37 + i * 113);
        logic [11:0] l = 12'(seed * 5 + i * 7);
        logic [11:0] t = l + 12'(i % 9) + 12'd3;
        return {2'b10, p, l, t};
    endfunction

    task automatic run_frame(input int n, input int seed, input int stall, input bit poke);
        logic [39:0] hw;
        logic [39:0] ew;
        logic [15:0] crc;
        logic [15:0] cnt;
        logic [33:0] tp;
        stall_mode = stall;
        nwords = 0;
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        hw  = hdr_ref(exp_fc);
        crc = crc_ref(16'hFFFF, hw);
        for (int i = 0; i < n; i++) begin
            ew = ev_ref(seed, i);
            hit_pixel = ew[37:24];
            hit_lead  = ew[23:12];
            hit_trail = ew[11:0];
            hit_valid = 1'b1;
            @(negedge clk);
            while (!hit_ready) @(negedge clk);
            @(posedge clk); #1;
            crc = crc_ref(crc, ew);
            frame_start = poke && (i == 0);   // R11: start while frame open
        end
        hit_valid = 1'b0;
        frame_start = 1'b0;
        wait (nwords >= 1);
        @(posedge clk); #1 frame_end = 1'b1;
        @(posedge clk); #1 frame_end = 1'b0;
        wait (nwords >= n + 2);
        @(posedge clk); #1;
        check(nwords == n + 2, "R2 word count", 40'(nwords), 40'(n + 2));
        check(cap[0] == hw, "R3 R5 header word", cap[0], hw);
        for (int i = 0; i < n && i < 40; i++)
            check(cap[i + 1] == ev_ref(seed, i), "R4 event word", cap[i + 1], ev_ref(seed, i));
        cnt = (n > 65535) ? 16'hFFFF : 16'(n);
        tp  = {2'b11, cnt, crc};
        check(last_w[39:38] == 2'b11, "R2 trailer type", 40'(last_w[39:38]), 40'd3);
        check(last_w[37:22] == cnt, "R6 R9 trailer count", 40'(last_w[37:22]), 40'(cnt));
        check(last_w[21:6] == crc, "R6 R7 trailer CRC", 40'(last_w[21:6]), 40'(crc));
        check(last_w[5:0] == ecc_ref(tp), "R5 trailer check bits", 40'(last_w[5:0]), 40'(ecc_ref(tp)));
        exp_fc = exp_fc + 8'd1;
    endtask

    // Frame table: {events, sink pattern, seed, expected words}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        {8'd0,  8'd0, 8'd11, 8'd2},
        {8'd1,  8'd0, 8'd23, 8'd3},
        {8'd3,  8'd1, 8'd5,  8'd5},
        {8'd7,  8'd2, 8'd91, 8'd9},
        {8'd12, 8'd1, 8'd42, 8'd14},
        {8'd40, 8'd2, 8'd77, 8'd42}
    };

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] fc0;
        repeat (3) @(negedge clk);
        check(!out_valid && !hit_ready, "R1 outputs during reset",
              40'({out_valid, hit_ready}), 40'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !hit_ready, "R1 outputs after reset",
              40'({out_valid, hit_ready}), 40'd0);

        // R11: frame_end while idle does nothing
        @(posedge clk); #1 frame_end = 1'b1;
        @(posedge clk); #1 frame_end = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!out_valid && !hit_ready, "R11 R12 idle frame_end ignored",
                  40'({out_valid, hit_ready}), 40'd0);
        end

        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VEC[v][31:24]), int'(VEC[v][15:8]), int'(VEC[v][23:16]), 1'b0);
            check(nwords == int'(VEC[v][7:0]), "R2 table word count",
                  40'(nwords), 40'(VEC[v][7:0]));
            if (v == 0) check(cap[0][25:18] == 8'd0, "R1 first frame number",
                              40'(cap[0][25:18]), 40'd0);
        end

        // R10 and R12: header held under a stalled sink, no hit taken in HEAD
        stall_mode = 3;
        nwords = 0;
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        hit_valid = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_word == hdr_ref(exp_fc), "R10 header held while stalled",
              out_word, hdr_ref(exp_fc));
        check(!hit_ready, "R12 no hit in HEAD", 40'(hit_ready), 40'd0);
        @(posedge clk); #1 hit_valid = 1'b0; stall_mode = 0;
        wait (nwords >= 1);
        @(posedge clk); #1 frame_end = 1'b1;
        @(posedge clk); #1 frame_end = 1'b0;
        wait (nwords >= 2);
        @(posedge clk); #1;
        check(nwords == 2 && last_w[37:22] == 16'd0, "R12 empty frame after stalled head",
              40'(last_w[37:22]), 40'd0);
        exp_fc = exp_fc + 8'd1;

        // R11: frame_start inside an open frame; next frame checks the number
        run_frame(4, 9, 1, 1'b1);
        run_frame(2, 3, 0, 1'b0);

        // R8: frame number wraps after 256 frames
        fc0 = exp_fc;
        for (int f = 0; f < 256; f++) run_frame(0, f, 0, 1'b0);
        run_frame(1, 6, 0, 1'b0);
        check(cap[0][25:18] == fc0, "R8 frame number wrap", 40'(cap[0][25:18]), 40'(fc0));

        // R9: event count saturation
        run_frame(65537, 13, 0, 1'b0);

        check(stab_err == 0, "R10 hold across all stalls", 40'(stab_err), 40'd0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule